// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block measures a fixed span of clock ticks. A start value is loaded into a down-counter. The counter then loses one per clock edge until it sits at zero. One edge after the count reaches zero, a registered expiry flag rises. The flag and the zero count then stay put until the clear input is pulsed. With the default start value of 1799 the span is 1800 ticks. That is thirty minutes when the clock runs at one tick per second.

Driving the clear input high holds the counter at its start value and keeps the flag low. Counting resumes on the first edge after clear returns low, so a high-then-low pulse restarts the timer. The pulse works after an expiry and also in the middle of a count. The current count is brought out so that the progress of the timer can be observed.

Top module: `interval_timer`

## Requirements
- R1: A synchronous active-high `rst` sets `count_o` to RELOAD and `expired_o` to 0 on the next rising edge.
- R2: On every edge where `clear_i` is high, `count_o` becomes RELOAD and `expired_o` becomes 0, however long `clear_i` stays high.
- R3: On each edge where `clear_i` is low and `count_o` is nonzero, `count_o` decreases by exactly one.
- R4: While `clear_i` is low and `count_o` is zero, `count_o` stays at zero and never wraps to its maximum value.
- R5: `expired_o` rises on the RELOAD+1'th edge after `clear_i` falls, which is the edge following the one that brought `count_o` to zero. It then stays high until `clear_i` goes high. With the default RELOAD of 1799 this span is 1800 edges.
- R6: `expired_o` is a register output and is high only while `count_o` is zero.
- R7: A high-then-low pulse on `clear_i` restarts the countdown from RELOAD. This holds after an expiry and also in the middle of a count, and the first decrement comes on the first edge after the fall.
- R8: The counter width is the smallest that holds RELOAD, which is 11 bits for the default of 1799.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per counted interval unit |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Active-high clear; reloads while high, counting starts after it falls |
| expired_o | output | 1 | Registered flag, high once the interval has elapsed |
| count_o | output | CW (11 by default) | Current counter value |

## Verification
The hardest state to reach is the resting state at zero, with the flag high and no wrap of the counter. It lies 1800 edges beyond a release of clear. The bench walks the whole default-length countdown and checks every intermediate count. It then idles at zero for a stretch before it pulses clear. A second pulse, given partway through a later countdown, shows that the restart does not depend on having expired first.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    CMD_LOAD = 2'd0,
    CMD_DEC  = 2'd1,
    CMD_HOLD = 2'd2
  } tmr_cmd_e;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import timer_pkg::*;
(
  input  logic     clear_i,
  input  logic     zero_i,
  output tmr_cmd_e cmd_o
);
  always_comb begin
    if (clear_i)     cmd_o = CMD_LOAD;
    else if (zero_i) cmd_o = CMD_HOLD;
    else             cmd_o = CMD_DEC;
  end
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt
  import timer_pkg::*;
#(
  parameter int unsigned RELOAD = 1799,
  parameter int unsigned CW     = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  tmr_cmd_e      cmd_i,
  output logic [CW-1:0] count_o,
  output logic          zero_o
);
  localparam logic [CW-1:0] START = CW'(RELOAD);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= START;
    end else begin
      case (cmd_i)
        CMD_LOAD: count_q <= START;
        CMD_DEC:  count_q <= count_q - CW'(1);
        default:  count_q <= count_q;
      endcase
    end
  end

  assign count_o = count_q;
  assign zero_o  = (count_q == '0);

  // R3: one step down per edge while counting
  p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_DEC) |=> (count_q == $past(count_q) - CW'(1)));

  // R4: no wrap past zero
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_HOLD) |=> (count_q == '0));

  // R2: load while cleared
  p_reload_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_LOAD) |=> (count_q == START));
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic zero_i,
  output logic expired_o
);
  logic expired_q;

  always_ff @(posedge clk) begin
    if (rst) expired_q <= 1'b0;
    else     expired_q <= zero_i & ~clear_i;
  end

  assign expired_o = expired_q;

  // R6: flag only alongside a zero count
  p_flag_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
    expired_q |-> zero_i);

  // R5: flag sticks until clear
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (expired_q && !clear_i) |=> expired_q);

  // R2: clear drops the flag
  p_clear_drops_r2: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !expired_q);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int unsigned RELOAD = 1799,
  localparam int unsigned CW = (RELOAD < 1) ? 1 : $clog2(RELOAD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  output logic          expired_o,
  output logic [CW-1:0] count_o
);
  tmr_cmd_e cmd;
  logic     zero;

  tmr_ctrl u_ctrl (
    .clear_i (clear_i),
    .zero_i  (zero),
    .cmd_o   (cmd)
  );

  tmr_down_cnt #(.RELOAD(RELOAD), .CW(CW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .cmd_i   (cmd),
    .count_o (count_o),
    .zero_o  (zero)
  );

  tmr_flag u_flag (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (clear_i),
    .zero_i    (zero),
    .expired_o (expired_o)
  );

  // R1: reset state
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (count_o == CW'(RELOAD) && !expired_o));
endmodule

// File: tb/interval_timer_test.sv
`timescale 1ns/1ps
module interval_timer_test;
  localparam int unsigned RELOAD = 1799;
  localparam int unsigned CW = $clog2(RELOAD + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clear_i = 1'b0;
  logic          expired_o;
  logic [CW-1:0] count_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  interval_timer #(.RELOAD(RELOAD)) uut (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (clear_i),
    .expired_o (expired_o),
    .count_o   (count_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; clear_i = 1'b0;
    tick(); tick();
    chk("R1 count", int'(count_o), RELOAD);
    chk("R1 expired", int'(expired_o), 0);
    chk("R8 width", $bits(count_o), 11);
    rst = 1'b0;
  endtask

  task automatic t_full_cycle();
    clear_i = 1'b1; tick();
    chk("R2 count", int'(count_o), RELOAD);
    clear_i = 1'b0;
    for (int k = 1; k <= int'(RELOAD); k++) begin
      tick();
      chk("R3 count", int'(count_o), RELOAD - k);
      chk("R5 early", int'(expired_o), 0);
    end
    tick();
    chk("R5 rise at 1800", int'(expired_o), 1);
    chk("R6 zero", int'(count_o), 0);
    for (int k = 0; k < 25; k++) begin
      tick();
      chk("R4 hold", int'(count_o), 0);
      chk("R5 sticky", int'(expired_o), 1);
    end
  endtask

  task automatic t_restart_after_expiry();
    clear_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R2 count", int'(count_o), RELOAD);
      chk("R2 expired", int'(expired_o), 0);
    end
    clear_i = 1'b0;
    tick();
    chk("R7 first step", int'(count_o), RELOAD - 1);
    tick();
    chk("R7 second step", int'(count_o), RELOAD - 2);
  endtask

  task automatic t_midcount_clear();
    for (int k = 0; k < 100; k++) tick();
    chk("R3 after 102", int'(count_o), RELOAD - 102);
    clear_i = 1'b1; tick();
    chk("R7 reload", int'(count_o), RELOAD);
    chk("R7 expired", int'(expired_o), 0);
    clear_i = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      tick();
      chk("R7 recount", int'(count_o), RELOAD - k);
    end
  endtask

  task automatic t_reset_midcount();
    rst = 1'b1; tick();
    chk("R1 mid reset", int'(count_o), RELOAD);
    chk("R1 mid flag", int'(expired_o), 0);
    rst = 1'b0; tick();
    chk("R3 after reset", int'(count_o), RELOAD - 1);
  endtask

  initial begin
    #1;
    t_reset();
    t_full_cycle();
    t_restart_after_expiry();
    t_midcount_clear();
    t_reset_midcount();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule